// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces horizontal sync, vertical sync, blanking, display enable and a line-compare pulse for a raster display. Each clock is one character time of 8 pixels, and the vertical position counts scanlines. The timing fields use the classic offset encoding. The horizontal total field holds the character count minus 5. The vertical total field holds the line count minus 2. Each display-end field holds the last visible character or line, so it is the count minus 1.

A sync or blank pulse starts when the counter equals the full-width start field. It ends when a narrow end field matches the low bits of the counter. An end field equal to the start's low bits therefore gives a pulse one full field wrap long. The counted timing fields go into a shadow copy while reset is held and on the last clock of each frame, so a frame never mixes old and new values. Polarity, sync-disable and screen-off act on the next clock.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts h_total_cfg+5 clocks and a frame lasts v_total_cfg+2 lines. Every output is registered and shows the counter position of the previous clock. The first position shown after reset release is character 0 of line 0.
- R2: disp_en is high for characters 0..h_disp_cfg of lines 0..v_disp_cfg and low everywhere else.
- R3: The horizontal sync window starts at character h_sync_start_cfg and lasts (h_sync_end_cfg - h_sync_start_cfg) mod 32 clocks. The 5-bit end field is compared with counter bits [4:0]. A result of 0 means 32 clocks.
- R4: The vertical sync window starts at line v_sync_start_cfg and lasts (v_sync_end_cfg - start) mod 16 lines. The 4-bit end field is compared with line bits [3:0]. A result of 0 means 16 lines.
- R5: blank is the OR of three terms: a horizontal window, a vertical window and screen_off. The horizontal window has a 6-bit end field over counter bits [5:0]. The vertical window has an 8-bit end field over line bits [7:0]. Both windows use the start/end rule of R3.
- R6: sync_neg[0]=1 makes hsync active-low and sync_neg[1]=1 makes vsync active-low.
- R7: sync_off[0]=1 holds hsync at its inactive level and sync_off[1]=1 does the same for vsync. The inactive level is the value of the matching sync_neg bit.
- R8: screen_off=1 forces disp_en low and blank high from the next clock on.
- R9: line_match is a one-clock pulse at character 0 of line line_cmp_cfg.
- R10: raster_line gives the 11-bit number of the line being shown.
- R11: New values on the total, display, blank, sync and line-compare inputs take effect only from the first position of the next frame.
- R12: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_total_cfg | input | 9 | Characters per line minus 5 |
| h_disp_cfg | input | 9 | Last visible character |
| h_blank_start_cfg | input | 9 | First blanked character |
| h_blank_end_cfg | input | 6 | Horizontal blank end, low 6 counter bits |
| h_sync_start_cfg | input | 9 | First hsync character |
| h_sync_end_cfg | input | 5 | Horizontal sync end, low 5 counter bits |
| v_total_cfg | input | 11 | Lines per frame minus 2 |
| v_disp_cfg | input | 11 | Last visible line |
| v_blank_start_cfg | input | 11 | First blanked line |
| v_blank_end_cfg | input | 8 | Vertical blank end, low 8 line bits |
| v_sync_start_cfg | input | 11 | First vsync line |
| v_sync_end_cfg | input | 4 | Vertical sync end, low 4 line bits |
| line_cmp_cfg | input | 11 | Line that raises line_match |
| sync_neg | input | 2 | Active-low select: [0] hsync, [1] vsync |
| sync_off | input | 2 | Sync suppress: [0] hsync, [1] vsync |
| screen_off | input | 1 | Force blanking |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Visible area |
| blank | output | 1 | Blanking |
| line_match | output | 1 | Line-compare pulse |
| raster_line | output | 11 | Line being shown |

## Verification
Each output appears one clock after the counter position it describes. A change on sync_neg, sync_off or screen_off therefore shows at the first sample after the next rising edge. A timing field changed mid-frame first shows at character 0 of line 0, which follows the edge that leaves the last position.

The bench keeps its own counter position and its own shadow copy, and advances both before each rising edge. It samples on the following falling edge and compares that sample with the position held before the edge. The shadow copy is reloaded from the live inputs only when the position being left is the frame's last.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Offsets removed from the totals by the encoding of the total fields.
  localparam int unsigned H_TOTAL_BIAS = 5;
  localparam int unsigned V_TOTAL_BIAS = 2;
endpackage

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
#(
  parameter int HW = 9,
  parameter int VW = 11,
  localparam int HCW = HW + 1,
  localparam int VCW = VW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  h_total,
  input  logic [VW-1:0]  v_total,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           line_end,
  output logic           frame_end
);
  function automatic logic [HCW-1:0] last_char(input logic [HW-1:0] t);
    return {1'b0, t} + HCW'(H_TOTAL_BIAS - 1);
  endfunction

  function automatic logic [VCW-1:0] last_line(input logic [VW-1:0] t);
    return {1'b0, t} + VCW'(V_TOTAL_BIAS - 1);
  endfunction

  assign line_end  = (hcnt == last_char(h_total));
  assign frame_end = line_end && (vcnt == last_line(v_total));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R1: the character counter never passes the last character of the line
  p_hcnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= last_char(h_total))
    else $error("R1 character counter beyond line end");
endmodule

// File: rtl/pulse_window.sv
module pulse_window #(
  parameter int CW = 10,
  parameter int SW = 9,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] start,
  input  logic [EW-1:0] stop,
  output logic          active
);
  logic run_q;
  logic hit_start;
  logic hit_stop;

  assign hit_start = (cnt == CW'(start));
  assign hit_stop  = (cnt[EW-1:0] == stop);
  assign active    = hit_start | (run_q & ~hit_stop);

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= 1'b0;
    else if (step) run_q <= active;
  end

  // R3/R4/R5: a stop match (without a new start) ends the running pulse
  p_stop_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && run_q && hit_stop && !hit_start) |=> !run_q)
    else $error("R3 pulse did not end on stop match");
  // R3/R4/R5: a start match always opens the pulse
  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hit_start) |=> run_q)
    else $error("R3 pulse did not open on start match");
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW    = 9,
  parameter int VW    = 11,
  parameter int HBE_W = 6,
  parameter int HSE_W = 5,
  parameter int VBE_W = 8,
  parameter int VSE_W = 4,
  localparam int HCW  = HW + 1,
  localparam int VCW  = VW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW-1:0]    h_total_cfg,
  input  logic [HW-1:0]    h_disp_cfg,
  input  logic [HW-1:0]    h_blank_start_cfg,
  input  logic [HBE_W-1:0] h_blank_end_cfg,
  input  logic [HW-1:0]    h_sync_start_cfg,
  input  logic [HSE_W-1:0] h_sync_end_cfg,
  input  logic [VW-1:0]    v_total_cfg,
  input  logic [VW-1:0]    v_disp_cfg,
  input  logic [VW-1:0]    v_blank_start_cfg,
  input  logic [VBE_W-1:0] v_blank_end_cfg,
  input  logic [VW-1:0]    v_sync_start_cfg,
  input  logic [VSE_W-1:0] v_sync_end_cfg,
  input  logic [VW-1:0]    line_cmp_cfg,
  input  logic [1:0]       sync_neg,
  input  logic [1:0]       sync_off,
  input  logic             screen_off,
  output logic             hsync,
  output logic             vsync,
  output logic             disp_en,
  output logic             blank,
  output logic             line_match,
  output logic [VW-1:0]    raster_line
);
  // Frame-stable copy of the counted timing fields
  logic [HW-1:0]    sh_htot, sh_hdisp, sh_hbs, sh_hss;
  logic [HBE_W-1:0] sh_hbe;
  logic [HSE_W-1:0] sh_hse;
  logic [VW-1:0]    sh_vtot, sh_vdisp, sh_vbs, sh_vss, sh_lcmp;
  logic [VBE_W-1:0] sh_vbe;
  logic [VSE_W-1:0] sh_vse;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           line_end, frame_end;
  logic           hs_act, vs_act, hb_act, vb_act;
  logic           h_vis, v_vis, at_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      sh_htot  <= h_total_cfg;
      sh_hdisp <= h_disp_cfg;
      sh_hbs   <= h_blank_start_cfg;
      sh_hbe   <= h_blank_end_cfg;
      sh_hss   <= h_sync_start_cfg;
      sh_hse   <= h_sync_end_cfg;
      sh_vtot  <= v_total_cfg;
      sh_vdisp <= v_disp_cfg;
      sh_vbs   <= v_blank_start_cfg;
      sh_vbe   <= v_blank_end_cfg;
      sh_vss   <= v_sync_start_cfg;
      sh_vse   <= v_sync_end_cfg;
      sh_lcmp  <= line_cmp_cfg;
    end
  end

  raster_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .h_total(sh_htot), .v_total(sh_vtot),
    .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end), .frame_end(frame_end)
  );

  pulse_window #(.CW(HCW), .SW(HW), .EW(HSE_W)) u_hsync (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .cnt(hcnt),
    .start(sh_hss), .stop(sh_hse), .active(hs_act)
  );
  pulse_window #(.CW(HCW), .SW(HW), .EW(HBE_W)) u_hblank (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .cnt(hcnt),
    .start(sh_hbs), .stop(sh_hbe), .active(hb_act)
  );
  pulse_window #(.CW(VCW), .SW(VW), .EW(VSE_W)) u_vsync (
    .clk(clk), .rst_n(rst_n), .step(line_end), .cnt(vcnt),
    .start(sh_vss), .stop(sh_vse), .active(vs_act)
  );
  pulse_window #(.CW(VCW), .SW(VW), .EW(VBE_W)) u_vblank (
    .clk(clk), .rst_n(rst_n), .step(line_end), .cnt(vcnt),
    .start(sh_vbs), .stop(sh_vbe), .active(vb_act)
  );

  assign h_vis  = (hcnt <= HCW'(sh_hdisp));
  assign v_vis  = (vcnt <= VCW'(sh_vdisp));
  assign at_cmp = (hcnt == '0) && (vcnt == VCW'(sh_lcmp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      disp_en     <= 1'b0;
      blank       <= 1'b0;
      line_match  <= 1'b0;
      raster_line <= '0;
    end else begin
      hsync       <= (hs_act & ~sync_off[0]) ^ sync_neg[0];
      vsync       <= (vs_act & ~sync_off[1]) ^ sync_neg[1];
      disp_en     <= h_vis & v_vis & ~screen_off;
      blank       <= hb_act | vb_act | screen_off;
      line_match  <= at_cmp;
      raster_line <= vcnt[VW-1:0];
    end
  end

  p_screen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    screen_off |=> (!disp_en && blank))
    else $error("R8 screen_off not honoured");
  p_hsync_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_off[0] |=> (hsync == $past(sync_neg[0])))
    else $error("R7 hsync not held inactive");
  p_vsync_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_off[1] |=> (vsync == $past(sync_neg[1])))
    else $error("R7 vsync not held inactive");
  p_match_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_match |=> !line_match)
    else $error("R9 line_match longer than one clock");
  p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(sh_htot) && $stable(sh_vtot)))
    else $error("R11 timing copy changed mid-frame");
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int htot, hde, hbs, hbe, hss, hse;
    int vtot, vde, vbs, vbe, vss, vse, lcmp;
  } tcfg_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] h_total_cfg, h_disp_cfg, h_blank_start_cfg, h_sync_start_cfg;
  logic [5:0] h_blank_end_cfg;
  logic [4:0] h_sync_end_cfg;
  logic [10:0] v_total_cfg, v_disp_cfg, v_blank_start_cfg, v_sync_start_cfg, line_cmp_cfg;
  logic [7:0] v_blank_end_cfg;
  logic [3:0] v_sync_end_cfg;
  logic [1:0] sync_neg = 2'b00;
  logic [1:0] sync_off = 2'b00;
  logic screen_off = 1'b0;
  logic hsync, vsync, disp_en, blank, line_match;
  logic [10:0] raster_line;

  int checks = 0;
  int failures = 0;
  tcfg_t live, shadow;
  int cur_h = 0, cur_v = 0;
  int n_match = 0, n_de = 0, max_line = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .h_total_cfg(h_total_cfg), .h_disp_cfg(h_disp_cfg),
    .h_blank_start_cfg(h_blank_start_cfg), .h_blank_end_cfg(h_blank_end_cfg),
    .h_sync_start_cfg(h_sync_start_cfg), .h_sync_end_cfg(h_sync_end_cfg),
    .v_total_cfg(v_total_cfg), .v_disp_cfg(v_disp_cfg),
    .v_blank_start_cfg(v_blank_start_cfg), .v_blank_end_cfg(v_blank_end_cfg),
    .v_sync_start_cfg(v_sync_start_cfg), .v_sync_end_cfg(v_sync_end_cfg),
    .line_cmp_cfg(line_cmp_cfg), .sync_neg(sync_neg), .sync_off(sync_off),
    .screen_off(screen_off), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .blank(blank), .line_match(line_match), .raster_line(raster_line)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", req, what, act, exp, cur_h, cur_v);
    end
  endtask

  // Window length rule: (end - start) modulo the end-field size, 0 meaning a full wrap
  function automatic bit in_win(int pos, int start, int stopv, int bits);
    int size = 1 << bits;
    int len = (stopv - start) & (size - 1);
    if (len == 0) len = size;
    return (pos >= start) && (pos < start + len);
  endfunction

  task automatic drive(input tcfg_t c);
    live = c;
    h_total_cfg = 9'(c.htot);        h_disp_cfg = 9'(c.hde);
    h_blank_start_cfg = 9'(c.hbs);   h_blank_end_cfg = 6'(c.hbe);
    h_sync_start_cfg = 9'(c.hss);    h_sync_end_cfg = 5'(c.hse);
    v_total_cfg = 11'(c.vtot);       v_disp_cfg = 11'(c.vde);
    v_blank_start_cfg = 11'(c.vbs);  v_blank_end_cfg = 8'(c.vbe);
    v_sync_start_cfg = 11'(c.vss);   v_sync_end_cfg = 4'(c.vse);
    line_cmp_cfg = 11'(c.lcmp);
  endtask

  // R12: outputs are 0 during reset; afterwards the model starts at (0,0)
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "hsync in reset", int'(hsync), 0);
    chk("R12", "vsync in reset", int'(vsync), 0);
    chk("R12", "disp_en in reset", int'(disp_en), 0);
    chk("R12", "blank in reset", int'(blank), 0);
    chk("R12", "line_match in reset", int'(line_match), 0);
    chk("R12", "raster_line in reset", int'(raster_line), 0);
    rst_n = 1'b1;
    shadow = live;
    cur_h = 0; cur_v = 0;
  endtask

  // One clock: the output after the edge shows the position held before it
  task automatic step();
    int eh = cur_h, ev = cur_v;
    tcfg_t ec = shadow;
    bit e;
    if (cur_h == ec.htot + 4) begin
      cur_h = 0;
      if (cur_v == ec.vtot + 1) begin cur_v = 0; shadow = live; end
      else cur_v++;
    end else cur_h++;
    @(posedge clk);
    @(negedge clk);
    e = (in_win(eh, ec.hss, ec.hse, 5) && !sync_off[0]) ^ sync_neg[0];
    chk(sync_off[0] ? "R7" : (sync_neg[0] ? "R6" : "R3"), "hsync", int'(hsync), int'(e));
    e = (in_win(ev, ec.vss, ec.vse, 4) && !sync_off[1]) ^ sync_neg[1];
    chk(sync_off[1] ? "R7" : (sync_neg[1] ? "R6" : "R4"), "vsync", int'(vsync), int'(e));
    e = (eh <= ec.hde) && (ev <= ec.vde) && !screen_off;
    chk(screen_off ? "R8" : "R2", "disp_en", int'(disp_en), int'(e));
    e = in_win(eh, ec.hbs, ec.hbe, 6) || in_win(ev, ec.vbs, ec.vbe, 8) || screen_off;
    chk(screen_off ? "R8" : "R5", "blank", int'(blank), int'(e));
    chk("R9", "line_match", int'(line_match), int'((eh == 0) && (ev == ec.lcmp)));
    chk("R10", "raster_line", int'(raster_line), ev);
    if (line_match) n_match++;
    if (disp_en) n_de++;
    if (int'(raster_line) > max_line) max_line = int'(raster_line);
  endtask

  tcfg_t cfg_a = '{htot:7, hde:7, hbs:8, hbe:11, hss:9, hse:11,
                   vtot:8, vde:5, vbs:6, vbe:9, vss:7, vse:9, lcmp:3};
  tcfg_t cfg_b = '{htot:40, hde:31, hbs:32, hbe:44, hss:10, hse:10,
                   vtot:20, vde:2, vbs:19, vbe:21, vss:3, vse:3, lcmp:21};
  tcfg_t cfg_c = '{htot:3, hde:3, hbs:4, hbe:7, hss:5, hse:6,
                   vtot:4, vde:3, vbs:4, vbe:5, vss:4, vse:5, lcmp:1};

  // R1/R2: two frames of 12 x 10 positions
  task automatic t_basic();
    drive(cfg_a); do_reset();
    n_match = 0; n_de = 0;
    repeat (240) step();
    chk("R1", "line_match count over two frames", n_match, 2);
    chk("R2", "disp_en count over two frames", n_de, 2 * 8 * 6);
  endtask

  // R6: both syncs active-low
  task automatic t_polarity();
    drive(cfg_a); do_reset();
    @(negedge clk) sync_neg = 2'b11;
    do_reset();
    repeat (120) step();
    sync_neg = 2'b00;
  endtask

  // R7: suppressed syncs stay at the inactive level, both polarities
  task automatic t_sync_off();
    drive(cfg_a); sync_off = 2'b11; sync_neg = 2'b01;
    do_reset();
    repeat (120) step();
    sync_neg = 2'b10;
    repeat (60) step();
    sync_off = 2'b00; sync_neg = 2'b00;
    repeat (60) step();
  endtask

  // R8: screen_off forces blanking, then releases
  task automatic t_screen_off();
    drive(cfg_a); do_reset();
    repeat (20) step();
    screen_off = 1'b1;
    repeat (50) step();
    screen_off = 1'b0;
    repeat (50) step();
  endtask

  // R3/R4/R5: end field equal to start low bits gives a full-wrap pulse
  task automatic t_wrap();
    drive(cfg_b); do_reset();
    repeat (45 * 22) step();
  endtask

  // R11: a mid-frame change waits for the next frame
  task automatic t_update();
    drive(cfg_a); do_reset();
    repeat (50) step();
    drive(cfg_c);
    max_line = 0;
    while (!(cur_h == 0 && cur_v == 0)) step();
    step();
    chk("R11", "last line of frame under old total", max_line, 9);
    max_line = 0;
    repeat (8 * 6 * 2 - 1) step();
    chk("R11", "last line of frame under new total", max_line, 5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    drive(cfg_a);
    t_basic();
    t_polarity();
    t_sync_off();
    t_screen_off();
    t_wrap();
    t_update();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule